// File: doc/BRIEF.md
# Gated 16-bit Timer

This block is a 16-bit up-counter that a processor reaches through a small byte-wide register port. It can count every cycle of the system clock, or count rising edges seen on an external clock pin. The external pin is sampled with the system clock, either directly or through a two-stage synchronizer. The counts from either source pass through a prescaler that divides by 1, 2, 4 or 8 before they advance the count.

A gate pin can suspend counting. This lets the timer measure how long an external signal stays low. When the count wraps from its all-ones value to zero, a sticky overflow flag is raised on an output pin. The flag stays set until software clears it. Software can load either count byte at any time, and every such load also restarts the prescaler.

Top module: `gated_timer16`

## Requirements
- R1: After reset, all four register addresses read 0x00 and the overflow flag output is low.
- R2: The control register sits at address 0 with this layout: bit 0 run, bit 1 external source, bit 2 synchronizer enable, bits 4:3 prescale select, bit 5 gate enable. Bits 7:6 always read 0, whatever is written to them.
- R3: With run set, the internal source selected and prescale select 0, the count rises by exactly one on every system clock edge.
- R4: Prescale select values 1, 2 and 3 make the count rise once every 2, 4 and 8 source ticks respectively.
- R5: A write to the count low byte (address 1) or the count high byte (address 2) loads that byte and restarts the prescaler from zero. The next increment therefore comes a full prescale period after the write.
- R6: With run and gate enable both set, the count advances only while gate_in is low. While gate_in is high, the count holds.
- R7: While run is 0, the count holds at its value, whatever the state of gate enable or gate_in.
- R8: With the external source selected and the synchronizer off, each rising edge of ext_clk adds one tick, and the count changes on the first system clock edge after the rise.
- R9: With the synchronizer on, each rising edge of ext_clk adds one tick, and the count changes on the third system clock edge after the rise.
- R10: When the count wraps from 0xFFFF to 0x0000, the overflow flag becomes 1 on the same clock edge.
- R11: The overflow flag reads at bit 0 of address 3. Writing 0 to that bit clears the flag, writing 1 leaves it unchanged, and it otherwise stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the internal count source |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 count low, 2 count high, 3 flag |
| reg_wr | input | 1 | Write strobe, acted on at the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| ext_clk | input | 1 | External count source, sampled by clk |
| gate_in | input | 1 | Gate pin; a high level suspends counting when gating is on |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The properties assume that ext_clk and gate_in change away from the rising edge of clk, and that register writes last exactly one cycle. The bench drives every input on the falling edge. It keeps ext_clk high or low for at least one full cycle, so each rise is seen exactly once. Count values are checked only after the timer has been stopped, or at fixed delays after a single controlled external edge. This makes every expected value a plain count of source ticks.

// File: rtl/timer16_pkg.sv
package timer16_pkg;

    localparam int BYTE_W    = 8;
    localparam int CNT_BYTES = 2;
    localparam int CNT_W     = BYTE_W * CNT_BYTES;
    localparam int ADDR_W    = 2;
    localparam int PS_SEL_W  = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_FLAG   = 2'd3;

    typedef struct packed {
        logic [1:0]          pad;      // bits 7:6, never stored
        logic                gate_en;  // bit 5
        logic [PS_SEL_W-1:0] ps_sel;   // bits 4:3
        logic                sync_en;  // bit 2
        logic                ext_sel;  // bit 1
        logic                run;      // bit 0
    } ctrl_t;

endpackage

// File: rtl/t16_clk_src.sv
module t16_clk_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic sync_en,
    output logic ext_edge
);

    typedef struct packed {
        logic [SYNC_STAGES:0] chain;
        logic                 raw_prev;
    } src_state_t;

    src_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain    = {st_q.chain[SYNC_STAGES-1:0], ext_clk};
        st_d.raw_prev = ext_clk;
        if (sync_en) begin
            ext_edge = st_q.chain[SYNC_STAGES-1] & ~st_q.chain[SYNC_STAGES];
        end else begin
            ext_edge = ext_clk & ~st_q.raw_prev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/t16_prescaler.sv
module t16_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             step
);

    localparam int MAX_SHIFT = (1 << SEL_W) - 1;
    localparam int DIV_W     = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic [DIV_W-1:0] limit;
    logic             at_limit;

    always_comb begin
        st_d     = st_q;
        limit    = ~({DIV_W{1'b1}} << sel);
        at_limit = ((st_q.div & limit) == limit);
        step     = tick & at_limit;
        if (clear) begin
            st_d.div = '0;
        end else if (tick) begin
            st_d.div = at_limit ? '0 : ((st_q.div + 1'b1) & limit);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/t16_counter.sv
module t16_counter #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NBYTES-1:0]        lane_wr,
    input  logic [BYTE_W-1:0]        wdata,
    input  logic                     step,
    output logic [BYTE_W*NBYTES-1:0] count,
    output logic                     wrap
);

    localparam int CNT_W = BYTE_W * NBYTES;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic             any_wr;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] merged;

    assign any_wr = |lane_wr;

    always_comb begin
        if (!any_wr && step) begin
            base = st_q.cnt + 1'b1;
        end else begin
            base = st_q.cnt;
        end
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        assign merged[i*BYTE_W +: BYTE_W] =
            lane_wr[i] ? wdata : base[i*BYTE_W +: BYTE_W];
    end

    always_comb begin
        st_d     = st_q;
        st_d.cnt = merged;
        wrap     = step & ~any_wr & (&st_q.cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/gated_timer16.sv
module gated_timer16
    import timer16_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              ext_clk,
    input  logic              gate_in,
    output logic              ovf_flag
);

    typedef struct packed {
        ctrl_t ctrl;
        logic  flag;
    } top_state_t;

    top_state_t           st_d, st_q;
    ctrl_t                ctrl_q;
    logic                 flag_q;
    logic [CNT_BYTES-1:0] lane_wr;
    logic                 cnt_wr;
    logic                 ext_edge;
    logic                 src_tick;
    logic                 gate_open;
    logic                 tick;
    logic                 step;
    logic                 wrap;
    logic [CNT_W-1:0]     count;

    assign ctrl_q = st_q.ctrl;
    assign flag_q = st_q.flag;

    always_comb begin
        for (int i = 0; i < CNT_BYTES; i++) begin
            lane_wr[i] = reg_wr && (reg_addr == ADDR_CNT_LO + ADDR_W'(i));
        end
        cnt_wr    = |lane_wr;
        gate_open = ~(ctrl_q.gate_en & gate_in);
        src_tick  = ctrl_q.ext_sel ? ext_edge : 1'b1;
        tick      = ctrl_q.run & gate_open & src_tick;
    end

    t16_clk_src #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_clk (ext_clk),
        .sync_en (ctrl_q.sync_en),
        .ext_edge(ext_edge)
    );

    t16_prescaler #(
        .SEL_W(PS_SEL_W)
    ) u_ps (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(cnt_wr),
        .tick (tick),
        .sel  (ctrl_q.ps_sel),
        .step (step)
    );

    t16_counter #(
        .BYTE_W(BYTE_W),
        .NBYTES(CNT_BYTES)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .lane_wr(lane_wr),
        .wdata  (reg_wdata),
        .step   (step),
        .count  (count),
        .wrap   (wrap)
    );

    always_comb begin
        st_d = st_q;
        if (reg_wr && reg_addr == ADDR_CTRL) begin
            st_d.ctrl     = ctrl_t'(reg_wdata);
            st_d.ctrl.pad = '0;
        end
        if (reg_wr && reg_addr == ADDR_FLAG && !reg_wdata[0]) begin
            st_d.flag = 1'b0;
        end
        if (wrap) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL:   reg_rdata = ctrl_q;
            ADDR_FLAG:   reg_rdata = {{(BYTE_W-1){1'b0}}, flag_q};
            default: begin
                for (int i = 0; i < CNT_BYTES; i++) begin
                    if (reg_addr == ADDR_CNT_LO + ADDR_W'(i)) begin
                        reg_rdata = count[i*BYTE_W +: BYTE_W];
                    end
                end
            end
        endcase
    end

    assign ovf_flag = flag_q;

endmodule

// File: rtl/t16_checks.sv
module t16_checks
    import timer16_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic [BYTE_W-1:0] reg_rdata,
    input logic              gate_in,
    input ctrl_t             ctrl,
    input logic [CNT_W-1:0]  count,
    input logic              flag
);

    // R2: padding bits of the control byte read as zero
    p_ctrl_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_CTRL) |-> (reg_rdata[7:6] == 2'b00));

    // R3: without a write the count moves by at most one per edge
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr) |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1)));

    // R6: a closed gate freezes the count
    p_gate_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run && ctrl.gate_en && gate_in && !reg_wr) |=> $stable(count));

    // R7: a stopped timer holds its count
    p_off_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run && !reg_wr) |=> $stable(count));

    // R10: reaching zero from all ones raises the flag on that edge
    p_wrap_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (count == {CNT_W{1'b1}} && !reg_wr) |=> (count != '0 || flag));

    // R11: only a zero written to the flag bit lowers the flag
    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(reg_wr && reg_addr == ADDR_FLAG && !reg_wdata[0])) |=> flag);

endmodule

bind gated_timer16 t16_checks u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .gate_in  (gate_in),
    .ctrl     (ctrl_q),
    .count    (count),
    .flag     (flag_q)
);

// File: tb/gated_timer16_test.sv
`timescale 1ns/1ps
module gated_timer16_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       ext_clk = 1'b0;
    logic       gate_in = 1'b0;
    logic       ovf_flag;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    localparam logic [7:0] C_RUN  = 8'h01;
    localparam logic [7:0] C_EXT  = 8'h02;
    localparam logic [7:0] C_SYNC = 8'h04;
    localparam logic [7:0] C_GATE = 8'h20;

    always #4 clk = ~clk;

    gated_timer16 uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ext_clk  (ext_clk),
        .gate_in  (gate_in),
        .ovf_flag (ovf_flag)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic read_count(output logic [15:0] c);
        logic [7:0] lo, hi;
        reg_read(2'd1, lo);
        reg_read(2'd2, hi);
        c = {hi, lo};
    endtask

    task automatic load_count(input logic [15:0] v);
        reg_write(2'd1, v[7:0]);
        reg_write(2'd2, v[15:8]);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // start, then stop after exactly 16 clock edges of run time
    task automatic run16(input logic [7:0] cfg);
        reg_write(2'd0, cfg);
        idle(14);
        reg_write(2'd0, 8'h00);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), d);
            check("R1 reset readback", {8'h00, d}, 16'h0000);
        end
        check("R1 reset flag pin", {15'd0, ovf_flag}, 16'h0000);
    endtask

    task automatic t_ctrl_pad;
        logic [7:0] d;
        reg_write(2'd0, 8'hC0);
        reg_read(2'd0, d);
        check("R2 pad bits", {8'h00, d}, 16'h0000);
        reg_write(2'd0, 8'hDA);
        reg_read(2'd0, d);
        check("R2 layout readback", {8'h00, d}, 16'h001A);
        reg_write(2'd0, 8'h00);
    endtask

    task automatic t_internal;
        logic [15:0] c;
        load_count(16'h0000);
        run16(C_RUN);
        read_count(c);
        check("R3 ratio 1", c, 16'd16);
    endtask

    task automatic t_ratios;
        logic [15:0] c;
        for (int s = 1; s < 4; s++) begin
            load_count(16'h0000);
            run16(C_RUN | 8'(s << 3));
            read_count(c);
            check($sformatf("R4 select %0d", s), c, 16'(16 >> s));
        end
    endtask

    task automatic t_ps_clear;
        logic [15:0] c;
        load_count(16'h0000);
        reg_write(2'd0, C_RUN | 8'h18);
        idle(3);                  // 4 ticks before the load
        reg_write(2'd1, 8'h10);   // restarts the divider
        idle(4);                  // 6 ticks after the load
        reg_write(2'd0, 8'h00);
        read_count(c);
        check("R5 load clears divider", c, 16'h0010);
    endtask

    task automatic t_gate;
        logic [15:0] c;
        load_count(16'h0000);
        gate_in = 1'b1;
        run16(C_RUN | C_GATE);
        read_count(c);
        check("R6 gate high holds", c, 16'h0000);
        gate_in = 1'b0;
        run16(C_RUN | C_GATE);
        read_count(c);
        check("R6 gate low counts", c, 16'd16);
    endtask

    task automatic t_off;
        logic [15:0] c;
        load_count(16'h1234);
        gate_in = 1'b0;
        reg_write(2'd0, C_GATE);
        idle(20);
        read_count(c);
        check("R7 off holds", c, 16'h1234);
        reg_write(2'd0, 8'h00);
    endtask

    task automatic ext_pulse;
        @(negedge clk); ext_clk = 1'b1;
        @(negedge clk); ext_clk = 1'b0;
    endtask

    task automatic t_ext_raw;
        logic [7:0] d;
        load_count(16'h0000);
        reg_write(2'd0, C_RUN | C_EXT);
        idle(3);
        reg_read(2'd1, d);
        check("R8 no count without edges", {8'h00, d}, 16'h0000);
        @(negedge clk); ext_clk = 1'b1;
        reg_read(2'd1, d);
        check("R8 before edge", {8'h00, d}, 16'h0000);
        @(negedge clk); ext_clk = 1'b0;
        reg_read(2'd1, d);
        check("R8 after first edge", {8'h00, d}, 16'h0001);
        idle(2);
        ext_pulse();
        idle(1);
        ext_pulse();
        idle(2);
        reg_read(2'd1, d);
        check("R8 three edges", {8'h00, d}, 16'h0003);
        reg_write(2'd0, 8'h00);
    endtask

    task automatic t_ext_sync;
        logic [7:0] d;
        load_count(16'h0000);
        reg_write(2'd0, C_RUN | C_EXT | C_SYNC);
        idle(4);
        @(negedge clk); ext_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_read(2'd1, d);
        check("R9 two edges after rise", {8'h00, d}, 16'h0000);
        @(negedge clk);
        reg_read(2'd1, d);
        check("R9 third edge after rise", {8'h00, d}, 16'h0001);
        idle(2);
        ext_clk = 1'b0;
        idle(4);
        reg_read(2'd1, d);
        check("R9 one count per rise", {8'h00, d}, 16'h0001);
        reg_write(2'd0, 8'h00);
    endtask

    task automatic t_overflow;
        logic [7:0] d;
        logic [15:0] c;
        load_count(16'hFFFF);
        reg_write(2'd3, 8'h00);
        reg_read(2'd3, d);
        check("R10 flag clear before wrap", {8'h00, d}, 16'h0000);
        reg_write(2'd0, C_RUN | C_EXT);
        @(negedge clk); ext_clk = 1'b1;
        @(negedge clk); ext_clk = 1'b0;
        reg_read(2'd3, d);
        check("R10 flag on wrap edge", {8'h00, d}, 16'h0001);
        reg_read(2'd1, d);
        check("R10 low byte wrapped", {8'h00, d}, 16'h0000);
        reg_write(2'd0, 8'h00);
        read_count(c);
        check("R10 count wrapped", c, 16'h0000);
    endtask

    task automatic t_flag_clear;
        logic [7:0] d;
        reg_write(2'd3, 8'h01);
        reg_read(2'd3, d);
        check("R11 one keeps flag", {8'h00, d}, 16'h0001);
        check("R11 flag pin", {15'd0, ovf_flag}, 16'h0001);
        reg_write(2'd3, 8'hFE);
        reg_read(2'd3, d);
        check("R11 zero clears flag", {8'h00, d}, 16'h0000);
        reg_write(2'd3, 8'h01);
        reg_read(2'd3, d);
        check("R11 one does not set", {8'h00, d}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_pad();
        t_internal();
        t_ratios();
        t_ps_clear();
        t_gate();
        t_off();
        t_ext_raw();
        t_ext_sync();
        t_overflow();
        t_flag_clear();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule